// File: doc/BRIEF.md
# Byte Register Slave for a Serial Transceiver

This block is a slave on a 32-bit processor bus that gives software five byte-wide registers for a serial transceiver. One register holds the next transmit byte, and one holds transmit control and status. One returns the last received byte, one reports receive status, and one carries serial parameters for the line logic. The line coding, clock recovery and bit-level transmit and receive datapaths sit outside this block. They appear here only as simple byte ports and two one-cycle strobes: one says the transmitter took its byte, the other says a received byte has arrived.

A master starts an access by driving slave select and address strobe low together. It presents a register address, a read/write line that is high for reads, and, on writes, the byte on the top lane of the data bus. The slave answers on the middle line of a three-line active-low acknowledge bus and keeps the other two lines and its error line high. It holds the acknowledge until the master lets go of the strobe. The master drops the strobe one clock after it sees the acknowledge and drops slave select one clock after that. Read data comes back on the top lane, and every lower bit reads as zero.

Top module: `xcvr_regslave`

## Requirements
- R1: After reset all three acknowledge lines and the error line are high, read data is all zero, transmit enable is low, and both the busy flag and the ready flag read as 0.
- R2: ack_n[1] goes low at the second rising edge that samples sel_n and strobe_n both low. It stays low while strobe_n stays low, and it returns high at the first edge that samples strobe_n high. ack_n[0], ack_n[2] and err_n are always high.
- R3: Addresses are decoded as 0 = transmit data, 1 = transmit control, 2 = receive data, 3 = receive status and 4 = serial parameters. Write bytes are taken from wdata[31:24]. Read bytes are returned on rdata[31:24] with rdata[23:0] zero, and rdata is all zero whenever ack_n[1] is high.
- R4: Bits 6:0 of the transmit control register can be written and read back. Bit 6 drives tx_en, so writing 0x40 sets tx_en high. Bit 7 of that register reads the transmit-busy flag, and writing to bit 7 has no effect.
- R5: Writing any byte to transmit data sets transmit-busy and puts that byte on tx_byte. The byte also reads back from address 0. A one-cycle tx_take pulse clears busy.
- R6: A one-cycle rx_valid pulse captures rx_byte into receive data and sets receive-ready. Ready reads in bit 7 of the receive status register, and bits 6:0 of that register read 0. A read of receive data clears ready. Writes to addresses 2 and 3 change nothing.
- R7: The serial parameter register at address 4 is a full read/write byte and drives ser_param.
- R8: Accesses to addresses 5 to 15 are acknowledged like any other. They read 0, and writes to them change no register.
- R9: If strobe_n rises before the acknowledge (one clock of strobe), there is no acknowledge, and a write in that cycle changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_n | input | 1 | Active-low slave select |
| strobe_n | input | 1 | Active-low address strobe |
| rd | input | 1 | High for read, low for write |
| addr | input | ADDR_W (4) | Register address |
| wdata | input | DATA_W (32) | Write data, byte on bits 31:24 |
| rdata | output | DATA_W (32) | Read data, byte on bits 31:24 |
| ack_n | output | 3 | Active-low acknowledge lines; only bit 1 is used |
| err_n | output | 1 | Active-low error, held high |
| tx_en | output | 1 | Transmit enable, bit 6 of transmit control |
| tx_byte | output | 8 | Byte most recently written to transmit data |
| tx_take | input | 1 | Transmitter has accepted the byte (one-cycle pulse) |
| rx_valid | input | 1 | A received byte is present on rx_byte (one-cycle pulse) |
| rx_byte | input | 8 | Received byte |
| ser_param | output | 8 | Serial parameter register contents |

## Verification
The assertions assume a well-behaved master. It lowers select and strobe together, keeps the address and read/write line stable until the acknowledge, and raises the strobe no earlier than it would on an ordinary or deliberately aborted cycle. They also assume tx_take and rx_valid are single-cycle pulses. The bench meets these assumptions by driving every bus access through one task that follows the release order. It sends the transceiver pulses only between bus cycles and draws addresses, data and operation kinds from $urandom with a fixed seed. Directed cases add the abort, the unmapped addresses and the flag set/clear sequences.

// File: rtl/xrs_pkg.sv
package xrs_pkg;
  parameter int DATA_W = 32;
  parameter int BYTE_W = 8;
  parameter int ACK_LINES = 3;
  parameter int ACK_USED = 1;

  localparam int REG_TXD = 0;
  localparam int REG_TXC = 1;
  localparam int REG_RXD = 2;
  localparam int REG_RXS = 3;
  localparam int REG_SER = 4;
  localparam int FLAG_BIT = BYTE_W - 1;
  localparam int TXEN_BIT = BYTE_W - 2;

  typedef enum logic [1:0] {
    BUS_IDLE = 2'd0,
    BUS_WAIT = 2'd1,
    BUS_ACK  = 2'd2
  } bus_state_t;

  // Place a byte on the most significant lane, lower lanes zero.
  function automatic logic [DATA_W-1:0] lane_put(input logic [BYTE_W-1:0] b);
    logic [DATA_W-1:0] w;
    w = '0;
    w[DATA_W-1 -: BYTE_W] = b;
    return w;
  endfunction

  // Extract the most significant byte lane.
  function automatic logic [BYTE_W-1:0] lane_get(input logic [DATA_W-1:0] w);
    return w[DATA_W-1 -: BYTE_W];
  endfunction
endpackage

// File: rtl/xrs_bus_fsm.sv
module xrs_bus_fsm
  import xrs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sel_n,
  input  logic strobe_n,
  output logic acc_fire,
  output logic ack_on
);
  bus_state_t state_q, state_d;
  logic start;

  assign start = !sel_n && !strobe_n;
  // The access commits on the edge that moves WAIT to ACK.
  assign acc_fire = (state_q == BUS_WAIT) && start;
  assign ack_on = (state_q == BUS_ACK);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      BUS_IDLE: if (start) state_d = BUS_WAIT;
      BUS_WAIT: state_d = start ? BUS_ACK : BUS_IDLE;
      BUS_ACK:  if (strobe_n) state_d = BUS_IDLE;
      default:  state_d = BUS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= BUS_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/xrs_regbank.sv
module xrs_regbank
  import xrs_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_fire,
  input  logic              acc_rd,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [BYTE_W-1:0] wbyte,
  input  logic              tx_take,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic [BYTE_W-1:0] rbyte,
  output logic              tx_busy,
  output logic              rx_ready,
  output logic              tx_en,
  output logic [BYTE_W-1:0] tx_byte,
  output logic [BYTE_W-1:0] ser_param
);
  logic [BYTE_W-2:0] txc_q;
  logic [BYTE_W-1:0] rxd_q;
  logic wr_txd, wr_txc, wr_ser, rd_rxd;

  assign wr_txd = acc_fire && !acc_rd && (acc_addr == ADDR_W'(REG_TXD));
  assign wr_txc = acc_fire && !acc_rd && (acc_addr == ADDR_W'(REG_TXC));
  assign wr_ser = acc_fire && !acc_rd && (acc_addr == ADDR_W'(REG_SER));
  assign rd_rxd = acc_fire &&  acc_rd && (acc_addr == ADDR_W'(REG_RXD));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txc_q     <= '0;
      tx_byte   <= '0;
      ser_param <= '0;
      tx_busy   <= 1'b0;
    end else begin
      if (wr_txd) tx_byte <= wbyte;
      if (wr_txc) txc_q <= wbyte[BYTE_W-2:0];
      if (wr_ser) ser_param <= wbyte;
      // A new transmit byte outranks a same-cycle acceptance.
      if (wr_txd)       tx_busy <= 1'b1;
      else if (tx_take) tx_busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxd_q    <= '0;
      rx_ready <= 1'b0;
    end else if (rx_valid) begin
      rxd_q    <= rx_byte;
      rx_ready <= 1'b1;
    end else if (rd_rxd) begin
      rx_ready <= 1'b0;
    end
  end

  assign tx_en = txc_q[TXEN_BIT];

  always_comb begin
    rbyte = '0;
    if (acc_addr == ADDR_W'(REG_TXD))      rbyte = tx_byte;
    else if (acc_addr == ADDR_W'(REG_TXC)) rbyte = {tx_busy, txc_q};
    else if (acc_addr == ADDR_W'(REG_RXD)) rbyte = rxd_q;
    else if (acc_addr == ADDR_W'(REG_RXS)) rbyte = {rx_ready, {(BYTE_W-1){1'b0}}};
    else if (acc_addr == ADDR_W'(REG_SER)) rbyte = ser_param;
  end
endmodule

// File: rtl/xcvr_regslave.sv
module xcvr_regslave
  import xrs_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              strobe_n,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [ACK_LINES-1:0] ack_n,
  output logic              err_n,
  output logic              tx_en,
  output logic [BYTE_W-1:0] tx_byte,
  input  logic              tx_take,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic [BYTE_W-1:0] ser_param
);
  logic acc_fire, ack_on, tx_busy, rx_ready;
  logic [BYTE_W-1:0] rbyte;
  logic [DATA_W-1:0] rdata_q;

  xrs_bus_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .strobe_n(strobe_n),
    .acc_fire(acc_fire), .ack_on(ack_on)
  );

  xrs_regbank #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .acc_fire(acc_fire), .acc_rd(rd),
    .acc_addr(addr), .wbyte(lane_get(wdata)), .tx_take(tx_take),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rbyte(rbyte),
    .tx_busy(tx_busy), .rx_ready(rx_ready), .tx_en(tx_en),
    .tx_byte(tx_byte), .ser_param(ser_param)
  );

  // Read data is launched with the acknowledge and cleared with it.
  always_ff @(posedge clk) begin
    if (!rst_n)        rdata_q <= '0;
    else if (acc_fire) rdata_q <= rd ? lane_put(rbyte) : '0;
    else if (strobe_n) rdata_q <= '0;
  end

  assign rdata = rdata_q;

  generate
    for (genvar i = 0; i < ACK_LINES; i++) begin : g_ack
      if (i == ACK_USED) begin : g_used
        assign ack_n[i] = !ack_on;
      end else begin : g_idle
        assign ack_n[i] = 1'b1;
      end
    end
  endgenerate

  assign err_n = 1'b1;
endmodule

// File: rtl/xrs_checker.sv
module xrs_checker
  import xrs_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic clk,
  input logic rst_n,
  input logic sel_n,
  input logic strobe_n,
  input logic rd,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdata,
  input logic [ACK_LINES-1:0] ack_n,
  input logic err_n,
  input logic acc_fire,
  input logic tx_busy,
  input logic rx_ready,
  input logic tx_take
);
  // R2
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_n && ack_n[0] && ack_n[2]);
  // R2
  ack_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_n[1]) |-> $past(!sel_n && !strobe_n));
  // R2
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_n[1] && !strobe_n) |=> !ack_n[1]);
  // R2
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_n |=> ack_n[1]);
  // R3
  rdata_only_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata != '0) |-> !ack_n[1]);
  // R3
  low_lanes_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DATA_W-BYTE_W-1:0] == '0);
  // R5
  busy_set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> $past(acc_fire && !rd && addr == ADDR_W'(REG_TXD)));
  // R5
  busy_clr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_busy) |-> $past(tx_take));
  // R6
  ready_clr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_ready) |-> $past(acc_fire && rd && addr == ADDR_W'(REG_RXD)));
endmodule

bind xcvr_regslave xrs_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .strobe_n(strobe_n), .rd(rd),
  .addr(addr), .rdata(rdata), .ack_n(ack_n), .err_n(err_n),
  .acc_fire(acc_fire), .tx_busy(tx_busy), .rx_ready(rx_ready),
  .tx_take(tx_take)
);

// File: tb/xcvr_regslave_tb_top.sv
module xcvr_regslave_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1, strobe_n = 1'b1, rd = 1'b1;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2:0] ack_n;
  logic err_n, tx_en, tx_take = 1'b0, rx_valid = 1'b0;
  logic [7:0] tx_byte, rx_byte = '0, ser_param;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // Bench model of the register state.
  logic [6:0] m_txc = '0;
  logic [7:0] m_txd = '0, m_rxd = '0, m_ser = '0;
  bit m_busy = 0, m_ready = 0;

  always #2.5 clk = ~clk;

  xcvr_regslave dut_i (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .strobe_n(strobe_n), .rd(rd),
    .addr(addr), .wdata(wdata), .rdata(rdata), .ack_n(ack_n), .err_n(err_n),
    .tx_en(tx_en), .tx_byte(tx_byte), .tx_take(tx_take), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .ser_param(ser_param)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [3:0] a);
    case (a)
      4'd0: return m_txd;
      4'd1: return {m_busy, m_txc};
      4'd2: return m_rxd;
      4'd3: return {m_ready, 7'h00};
      4'd4: return m_ser;
      default: return 8'h00;
    endcase
  endfunction

  function automatic void model_write(input logic [3:0] a, input logic [7:0] b);
    case (a)
      4'd0: begin m_txd = b; m_busy = 1; end
      4'd1: m_txc = b[6:0];
      4'd4: m_ser = b;
      default: ;
    endcase
  endfunction

  task automatic bus_op(input bit is_rd, input logic [3:0] a, input logic [7:0] wb,
                        output logic [7:0] rb);
    int lat;
    @(negedge clk);
    sel_n = 0; strobe_n = 0; rd = is_rd; addr = a;
    wdata = {wb, 24'($urandom)};
    lat = 0;
    do begin @(negedge clk); lat++; end while (ack_n[1] && lat < 255);
    chk("R2 ack latency", lat, 2);
    chk("R2 other lines", {ack_n[0], ack_n[2], err_n}, 3'b111);
    chk("R3 low lanes", rdata[23:0], 24'h0);
    rb = rdata[31:24];
    strobe_n = 1;
    @(negedge clk);
    chk("R2 ack release", ack_n[1], 1'b1);
    chk("R3 rdata idle", rdata, 32'h0);
    sel_n = 1; rd = 1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] b);
    logic [7:0] dummy;
    bus_op(0, a, b, dummy);
    model_write(a, b);
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a);
    logic [7:0] got, exp;
    exp = exp_read(a);
    bus_op(1, a, 8'h00, got);
    chk(req, got, exp);
    if (a == 4'd2) m_ready = 0;
  endtask

  task automatic pulse_take();
    @(negedge clk); tx_take = 1;
    @(negedge clk); tx_take = 0;
    m_busy = 0;
  endtask

  task automatic pulse_rx(input logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_byte = b;
    @(negedge clk); rx_valid = 0;
    m_rxd = b; m_ready = 1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] sv;
    process::self().srandom(32'd20240611);
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ack/err", {ack_n, err_n}, 4'b1111);
    chk("R1 rdata", rdata, 32'h0);
    chk("R1 tx_en", tx_en, 1'b0);
    rd_chk("R1 busy clear", 4'd1);
    rd_chk("R1 ready clear", 4'd3);

    // R4 transmit enable
    wr(4'd1, 8'h40);
    chk("R4 tx_en high", tx_en, 1'b1);
    rd_chk("R4 ctl readback", 4'd1);
    wr(4'd1, 8'hBF);
    chk("R4 tx_en low", tx_en, 1'b0);
    rd_chk("R4 bit7 not writable", 4'd1);
    wr(4'd1, 8'h40);

    // R5 transmit busy
    wr(4'd0, 8'h55);
    chk("R5 tx_byte", tx_byte, 8'h55);
    rd_chk("R5 busy set", 4'd1);
    rd_chk("R5 data readback", 4'd0);
    pulse_take();
    rd_chk("R5 busy cleared", 4'd1);

    // R6 receive ready
    pulse_rx(8'h55);
    rd_chk("R6 ready set", 4'd3);
    wr(4'd2, 8'hAA);
    wr(4'd3, 8'hFF);
    rd_chk("R6 writes ignored", 4'd3);
    rd_chk("R6 rx data", 4'd2);
    rd_chk("R6 ready cleared", 4'd3);

    // R7 serial parameters
    wr(4'd4, 8'hA5);
    chk("R7 ser_param", ser_param, 8'hA5);
    rd_chk("R7 readback", 4'd4);

    // R8 unmapped addresses
    for (int a = 5; a < 16; a++) begin
      wr(4'(a), 8'($urandom));
      rd_chk("R8 unmapped reads zero", 4'(a));
    end
    for (int a = 0; a < 5; a++) rd_chk("R8 no side effect", 4'(a));

    // R9 aborted cycle: one clock of strobe, no ack, no write
    @(negedge clk);
    sel_n = 0; strobe_n = 0; rd = 0; addr = 4'd4; wdata = 32'h3C00_0000;
    @(negedge clk);
    chk("R9 no ack yet", ack_n[1], 1'b1);
    strobe_n = 1;
    @(negedge clk);
    chk("R9 no ack", ack_n[1], 1'b1);
    sel_n = 1; rd = 1;
    @(negedge clk);
    chk("R9 ser unchanged", ser_param, m_ser);
    rd_chk("R9 readback unchanged", 4'd4);

    // Constrained random mix against the model (R3 R4 R5 R6 R7 R8)
    for (int i = 0; i < 300; i++) begin
      int k;
      logic [3:0] a;
      logic [7:0] b;
      k = $urandom_range(0, 9);
      a = (k < 8) ? 4'($urandom_range(0, 5)) : 4'($urandom);
      b = 8'($urandom);
      if (k < 4) begin
        wr(a, b);
        chk("R4 tx_en follows bit6", tx_en, m_txc[6]);
        chk("R5 tx_byte port", tx_byte, m_txd);
        chk("R7 ser_param port", ser_param, m_ser);
      end else if (k < 8) rd_chk("R3 random read", a);
      else if (k == 8) pulse_take();
      else pulse_rx(b);
    end
    rd_chk("R5 final ctl", 4'd1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule